// File: doc/BRIEF.md
# Load Queue Ordering Guard

This block is the load queue of an out-of-order core. It lets loads finish in any order while making them look as if they were observed in program order. Loads enter the queue in program order. Each entry holds the load's cache-line address and a flag that marks write-combining memory. The core marks an entry complete when its data arrives, and frees the oldest entry at retirement once that entry is complete. A younger load never waits for an older one to get its data.

The queue also watches two kinds of line event from the private cache: remote invalidations and evictions. It handles both in the same way. Each event line is compared with every live entry.

An ordering hazard exists when the event hits a load that has already completed while some older load that needs ordering still waits for data. The check is deliberately conservative and compares no data. When a hazard is found, the queue picks the oldest such entry and raises a one-cycle flush request carrying its index. In the same cycle it drops that entry and everything younger, and rolls the tail back to it, so the load is reissued and its dependants are replayed.

Top module: `lq_order_guard`

## Requirements
- R1: While `rst` is high at a clock edge, the queue empties: head, tail and count go to 0 and `flush_valid` goes low.
- R2: An allocation writes the slot at the tail and advances the tail by one; while `q_full` is high (count equals DEPTH) an allocation is ignored.
- R3: `done_valid` marks any live entry complete, in any order. `retire_valid` frees the head entry only when that entry is complete; otherwise, or when the queue is empty, it has no effect.
- R4: An event whose line equals a live, completed, ordered entry (`alloc_wc` was 0) is a hazard when an older live entry is still incomplete and ordered. One cycle later `flush_valid` is high for exactly one cycle, and `flush_idx` holds that entry's slot.
- R5: An event that only matches entries that are not yet complete raises no flush.
- R6: A completed entry that is matched while all older ordered entries are complete raises no flush.
- R7: Entries allocated with `alloc_wc`=1 are never reported, and an incomplete write-combining entry does not count as a pending older load.
- R8: An eviction (`snp_evict`) is checked exactly like an invalidation (`snp_inv`).
- R9: When several entries qualify in one cycle, the one nearest the head is reported.
- R10: On a hazard, the reported slot and all younger slots are dropped and the tail is set to the reported slot. Older entries are kept. An allocation in the same cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Allocate a load at the tail |
| alloc_line | input | LINE_W | Cache-line address of the new load |
| alloc_wc | input | 1 | 1 = write-combining load, exempt from ordering |
| done_valid | input | 1 | Data returned for slot `done_idx` |
| done_idx | input | IDX_W | Slot whose load completed |
| retire_valid | input | 1 | Free the head slot if it is complete |
| snp_inv | input | 1 | Remote invalidation of line `snp_line` |
| snp_evict | input | 1 | Private-cache eviction of line `snp_line` |
| snp_line | input | LINE_W | Line address of the event |
| flush_valid | output | 1 | Registered one-cycle flush request |
| flush_idx | output | IDX_W | Slot to reissue from |
| head_idx | output | IDX_W | Oldest slot |
| tail_idx | output | IDX_W | Next slot to allocate |
| q_count | output | IDX_W+1 | Number of live entries |
| q_full | output | 1 | Count equals DEPTH |
| q_empty | output | 1 | Count is zero |

## Verification
Allocation, completion, retirement and the flush rollback all act on the clock edge that samples the command. So `head_idx`, `tail_idx`, `q_count`, `q_full` and `q_empty` reflect that command as soon as the edge has passed. The flush request is registered on that same edge, so `flush_valid` and `flush_idx` for an event presented before edge N can be read just after edge N, in the same cycle as the rolled-back tail. The bench drives inputs and samples outputs 1 ns after each rising edge. Its model advances exactly one step per edge, so every expected value lines up with that edge.

// File: rtl/lqg_pkg.sv
package lqg_pkg;

  // Per-slot status bits of the load queue.
  typedef struct packed {
    logic valid;  // slot holds a live load
    logic done;   // data has returned
    logic wc;     // write-combining: exempt from ordering
  } lqg_flags_t;

  // True when a slot takes part in load-to-load ordering.
  function automatic logic lqg_ordered(input lqg_flags_t f);
    return f.valid && !f.wc;
  endfunction

endpackage

// File: rtl/lqg_ptrs.sv
module lqg_ptrs #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv_tail,
  input  logic             adv_head,
  input  logic             roll_tail,
  input  logic [IDX_W-1:0] roll_off,
  output logic [PTR_W-1:0] head_ptr,
  output logic [PTR_W-1:0] tail_ptr
);

  // The extra top bit tells full from empty when the indices are equal.
  always_ff @(posedge clk) begin
    if (rst) begin
      head_ptr <= '0;
      tail_ptr <= '0;
    end else begin
      if (adv_head) head_ptr <= head_ptr + PTR_W'(1);
      if (roll_tail)     tail_ptr <= head_ptr + PTR_W'(roll_off);
      else if (adv_tail) tail_ptr <= tail_ptr + PTR_W'(1);
    end
  end

endmodule

// File: rtl/lqg_entries.sv
module lqg_entries
  import lqg_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int LINE_W = 26,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [IDX_W-1:0]              wr_idx,
  input  logic [LINE_W-1:0]             wr_line,
  input  logic                          wr_wc,
  input  logic                          done_en,
  input  logic [IDX_W-1:0]              done_idx,
  input  logic                          free_en,
  input  logic [IDX_W-1:0]              free_idx,
  input  logic [DEPTH-1:0]              kill_mask,
  output lqg_flags_t [DEPTH-1:0]        flags,
  output logic [DEPTH-1:0][LINE_W-1:0]  lines
);

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic              v_q, d_q, w_q;
    logic [LINE_W-1:0] line_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        v_q <= 1'b0;
        d_q <= 1'b0;
        w_q <= 1'b0;
      end else if (kill_mask[g]) begin
        v_q <= 1'b0;
        d_q <= 1'b0;
      end else if (wr_en && wr_idx == IDX_W'(g)) begin
        v_q <= 1'b1;
        d_q <= 1'b0;
        w_q <= wr_wc;
      end else begin
        if (done_en && done_idx == IDX_W'(g)) d_q <= 1'b1;
        if (free_en && free_idx == IDX_W'(g)) v_q <= 1'b0;
      end
    end

    // The line store has no reset and a single write port.
    always_ff @(posedge clk) begin
      if (wr_en && wr_idx == IDX_W'(g)) line_q <= wr_line;
    end

    assign flags[g] = '{valid: v_q, done: d_q, wc: w_q};
    assign lines[g] = line_q;
  end

endmodule

// File: rtl/lqg_violation.sv
module lqg_violation
  import lqg_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int LINE_W = 26,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  lqg_flags_t [DEPTH-1:0]        flags,
  input  logic [DEPTH-1:0][LINE_W-1:0]  lines,
  input  logic [IDX_W-1:0]              head_idx,
  input  logic                          evt_valid,
  input  logic [LINE_W-1:0]             evt_line,
  output logic                          found,
  output logic [IDX_W-1:0]              viol_idx,
  output logic [IDX_W-1:0]              viol_off
);

  logic             pend_seen;
  logic [IDX_W-1:0] id;

  // Walk the slots from oldest to youngest. The first completed ordered
  // match seen after an incomplete ordered slot is the one to report.
  always_comb begin
    found     = 1'b0;
    viol_idx  = '0;
    viol_off  = '0;
    pend_seen = 1'b0;
    id        = '0;
    for (int k = 0; k < DEPTH; k++) begin
      id = head_idx + IDX_W'(k);
      if (lqg_ordered(flags[id])) begin
        if (!found && evt_valid && pend_seen && flags[id].done &&
            lines[id] == evt_line) begin
          found    = 1'b1;
          viol_idx = id;
          viol_off = IDX_W'(k);
        end
        if (!flags[id].done) pend_seen = 1'b1;
      end
    end
  end

endmodule

// File: rtl/lq_order_guard.sv
module lq_order_guard
  import lqg_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int LINE_W = 26,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc_valid,
  input  logic [LINE_W-1:0] alloc_line,
  input  logic              alloc_wc,
  input  logic              done_valid,
  input  logic [IDX_W-1:0]  done_idx,
  input  logic              retire_valid,
  input  logic              snp_inv,
  input  logic              snp_evict,
  input  logic [LINE_W-1:0] snp_line,
  output logic              flush_valid,
  output logic [IDX_W-1:0]  flush_idx,
  output logic [IDX_W-1:0]  head_idx,
  output logic [IDX_W-1:0]  tail_idx,
  output logic [PTR_W-1:0]  q_count,
  output logic              q_full,
  output logic              q_empty
);

  logic [PTR_W-1:0]               head_ptr, tail_ptr, count;
  logic [IDX_W-1:0]               head_i, tail_i;
  lqg_flags_t [DEPTH-1:0]         flags;
  logic [DEPTH-1:0][LINE_W-1:0]   lines;
  logic                           found;
  logic [IDX_W-1:0]               viol_idx, viol_off, rel;
  logic [DEPTH-1:0]               kill_mask;
  logic                           do_alloc, do_retire, do_done, full, empty;
  logic                           flush_q;
  logic [IDX_W-1:0]               flush_idx_q;

  assign head_i = head_ptr[IDX_W-1:0];
  assign tail_i = tail_ptr[IDX_W-1:0];
  assign count  = tail_ptr - head_ptr;
  assign full   = (count == PTR_W'(DEPTH));
  assign empty  = (count == '0);

  assign do_alloc  = alloc_valid && !full && !found;
  assign do_retire = retire_valid && !empty && flags[head_i].done;
  assign do_done   = done_valid && flags[done_idx].valid;

  // Drop the reported slot and every slot younger than it.
  always_comb begin
    rel = '0;
    for (int g = 0; g < DEPTH; g++) begin
      rel          = IDX_W'(g) - head_i;
      kill_mask[g] = found && (rel >= viol_off);
    end
  end

  lqg_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk      (clk),
    .rst      (rst),
    .adv_tail (do_alloc),
    .adv_head (do_retire),
    .roll_tail(found),
    .roll_off (viol_off),
    .head_ptr (head_ptr),
    .tail_ptr (tail_ptr)
  );

  lqg_entries #(.DEPTH(DEPTH), .LINE_W(LINE_W)) u_entries (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (do_alloc),
    .wr_idx   (tail_i),
    .wr_line  (alloc_line),
    .wr_wc    (alloc_wc),
    .done_en  (do_done),
    .done_idx (done_idx),
    .free_en  (do_retire),
    .free_idx (head_i),
    .kill_mask(kill_mask),
    .flags    (flags),
    .lines    (lines)
  );

  lqg_violation #(.DEPTH(DEPTH), .LINE_W(LINE_W)) u_viol (
    .flags    (flags),
    .lines    (lines),
    .head_idx (head_i),
    .evt_valid(snp_inv || snp_evict),
    .evt_line (snp_line),
    .found    (found),
    .viol_idx (viol_idx),
    .viol_off (viol_off)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      flush_q     <= 1'b0;
      flush_idx_q <= '0;
    end else begin
      flush_q     <= found;
      flush_idx_q <= viol_idx;
    end
  end

  assign flush_valid = flush_q;
  assign flush_idx   = flush_idx_q;
  assign head_idx    = head_i;
  assign tail_idx    = tail_i;
  assign q_count     = count;
  assign q_full      = full;
  assign q_empty     = empty;

endmodule

// File: rtl/lqg_checks.sv
module lqg_checks #(
  parameter int DEPTH  = 8,
  parameter int LINE_W = 26,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rst,
  input logic             alloc_valid,
  input logic             retire_valid,
  input logic             snp_inv,
  input logic             snp_evict,
  input logic             flush_valid,
  input logic [IDX_W-1:0] flush_idx,
  input logic [IDX_W-1:0] head_idx,
  input logic [IDX_W-1:0] tail_idx,
  input logic             q_full,
  input logic             q_empty
);

  logic rst_d = 1'b0;
  always_ff @(posedge clk) rst_d <= rst;

  // R1: the cycle after a reset edge shows an empty queue and no flush.
  assert_reset_empty_R1: assert property (@(posedge clk)
    (rst_d && !rst) |-> (q_empty && !flush_valid));

  // R2: an allocation into a full queue leaves the tail alone.
  assert_full_alloc_ignored_R2: assert property (@(posedge clk) disable iff (rst)
    (alloc_valid && q_full) |=> (flush_valid || tail_idx == $past(tail_idx)));

  // R3: a retire request on an empty queue does not move the head.
  assert_empty_retire_ignored_R3: assert property (@(posedge clk) disable iff (rst)
    (retire_valid && q_empty) |=> (head_idx == $past(head_idx)));

  // R4, R8: a flush always follows a snoop or eviction one edge earlier.
  assert_flush_has_event_R4: assert property (@(posedge clk) disable iff (rst)
    flush_valid |-> $past(snp_inv || snp_evict));

  // R10: the tail sits on the reported slot when the flush is seen.
  assert_tail_rollback_R10: assert property (@(posedge clk) disable iff (rst)
    flush_valid |-> (tail_idx == flush_idx));

  // R6: a hazard needs an older pending load, which survives the flush.
  assert_older_kept_R6: assert property (@(posedge clk) disable iff (rst)
    flush_valid |-> !q_empty);

endmodule

bind lq_order_guard lqg_checks #(.DEPTH(DEPTH), .LINE_W(LINE_W)) u_lqg_checks (.*);

// File: tb/lq_order_guard_bench.sv
module lq_order_guard_bench;
  localparam int D  = 8;
  localparam int LW = 26;
  localparam int IW = $clog2(D);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          alloc_valid = 0, alloc_wc = 0, done_valid = 0, retire_valid = 0;
  logic          snp_inv = 0, snp_evict = 0;
  logic [LW-1:0] alloc_line = '0, snp_line = '0;
  logic [IW-1:0] done_idx = '0;
  logic          flush_valid, q_full, q_empty;
  logic [IW-1:0] flush_idx, head_idx, tail_idx;
  logic [IW:0]   q_count;

  int checks = 0, fails = 0;

  // Reference model state
  bit m_valid[D], m_done[D], m_wc[D];
  int m_line[D];
  int m_head = 0, m_count = 0, m_fidx = 0;
  bit m_fv = 0;

  always #10 clk = ~clk;

  lq_order_guard #(.DEPTH(D), .LINE_W(LW)) u_lq_order_guard (
    .clk(clk), .rst(rst), .alloc_valid(alloc_valid), .alloc_line(alloc_line),
    .alloc_wc(alloc_wc), .done_valid(done_valid), .done_idx(done_idx),
    .retire_valid(retire_valid), .snp_inv(snp_inv), .snp_evict(snp_evict),
    .snp_line(snp_line), .flush_valid(flush_valid), .flush_idx(flush_idx),
    .head_idx(head_idx), .tail_idx(tail_idx), .q_count(q_count),
    .q_full(q_full), .q_empty(q_empty));

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < D; i++) begin
      m_valid[i] = 0; m_done[i] = 0; m_wc[i] = 0; m_line[i] = 0;
    end
    m_head = 0; m_count = 0; m_fv = 0; m_fidx = 0;
  endtask

  task automatic compare(input string req);
    int tl;
    tl = (m_head + m_count) % D;
    chk(q_count == m_count, req, "q_count", int'(q_count), m_count);
    chk(head_idx == m_head, req, "head_idx", int'(head_idx), m_head);
    chk(tail_idx == tl, req, "tail_idx", int'(tail_idx), tl);
    chk(q_full == (m_count == D), req, "q_full", int'(q_full), int'(m_count == D));
    chk(q_empty == (m_count == 0), req, "q_empty", int'(q_empty), int'(m_count == 0));
    chk(flush_valid == m_fv, req, "flush_valid", int'(flush_valid), int'(m_fv));
    if (m_fv) chk(flush_idx == m_fidx, req, "flush_idx", int'(flush_idx), m_fidx);
  endtask

  // One clock: step the model from the current inputs, then compare.
  task automatic tick(input string req);
    bit found = 0, pend = 0, do_al, do_ret, do_dn;
    int vi = 0, voff = 0, tl, id, cnt;
    tl = (m_head + m_count) % D;
    for (int k = 0; k < m_count; k++) begin
      id = (m_head + k) % D;
      if (!m_wc[id]) begin
        if (!found && (snp_inv || snp_evict) && pend && m_done[id] &&
            m_line[id] == int'(snp_line)) begin
          found = 1; vi = id; voff = k;
        end
        if (!m_done[id]) pend = 1;
      end
    end
    do_al  = alloc_valid && m_count < D && !found;
    do_ret = retire_valid && m_count > 0 && m_done[m_head];
    do_dn  = done_valid && m_valid[done_idx];
    if (do_dn) m_done[done_idx] = 1;
    if (do_al) begin
      m_valid[tl] = 1; m_done[tl] = 0; m_wc[tl] = alloc_wc; m_line[tl] = int'(alloc_line);
    end
    cnt = m_count + int'(do_al) - int'(do_ret);
    if (found) begin
      for (int k = voff; k < D; k++) m_valid[(m_head + k) % D] = 0;
      cnt = voff - int'(do_ret);
    end
    if (do_ret) begin
      m_valid[m_head] = 0;
      m_head = (m_head + 1) % D;
    end
    m_count = cnt;
    m_fv = found;
    m_fidx = vi;
    @(posedge clk);
    #1;
    compare(req);
  endtask

  task automatic clear_inputs();
    alloc_valid = 0; alloc_wc = 0; done_valid = 0; retire_valid = 0;
    snp_inv = 0; snp_evict = 0;
  endtask

  task automatic do_alloc(input int line, input bit wc, input string req);
    alloc_valid = 1; alloc_line = LW'(line); alloc_wc = wc;
    tick(req); clear_inputs();
  endtask

  task automatic do_done(input int idx, input string req);
    done_valid = 1; done_idx = IW'(idx);
    tick(req); clear_inputs();
  endtask

  task automatic do_snoop(input int line, input bit evict, input string req);
    snp_line = LW'(line); snp_inv = !evict; snp_evict = evict;
    tick(req); clear_inputs();
  endtask

  task automatic do_retire(input string req);
    retire_valid = 1;
    tick(req); clear_inputs();
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    model_reset();
    rst = 1;
    repeat (3) @(posedge clk);
    #1;
    rst = 0;
    compare("R1");

    // R2: in-order allocation
    do_alloc(10, 0, "R2"); do_alloc(11, 0, "R2");
    do_alloc(12, 0, "R2"); do_alloc(13, 0, "R2");
    // R3: out-of-order completion, then the R4 hazard on slot 1
    do_done(2, "R3"); do_done(1, "R3");
    do_snoop(11, 0, "R4");
    chk(flush_valid && flush_idx == 1, "R4", "flush slot1", int'(flush_idx), 1);
    chk(q_count == 1, "R10", "count after flush", int'(q_count), 1);
    do_snoop(11, 0, "R4");
    chk(!flush_valid, "R4", "single-cycle flush", int'(flush_valid), 0);

    // R5: event hits a pending load only
    do_alloc(20, 0, "R5"); do_alloc(21, 0, "R5");
    do_snoop(21, 0, "R5");
    chk(!flush_valid, "R5", "pending hit", int'(flush_valid), 0);
    // R6: no older pending
    do_done(0, "R6"); do_done(1, "R6"); do_done(2, "R6");
    do_snoop(21, 0, "R6");
    chk(!flush_valid, "R6", "all older done", int'(flush_valid), 0);

    // R7: write-combining exemption
    do_retire("R3"); do_retire("R3"); do_retire("R3");
    do_alloc(30, 0, "R7"); do_alloc(31, 1, "R7"); do_alloc(32, 0, "R7");
    do_done(4, "R7");
    do_snoop(31, 0, "R7");
    chk(!flush_valid, "R7", "wc hit", int'(flush_valid), 0);
    do_alloc(40, 1, "R7"); do_alloc(41, 0, "R7");
    do_done(3, "R7"); do_done(5, "R7"); do_done(7, "R7");
    do_snoop(41, 0, "R7");
    chk(!flush_valid, "R7", "wc pending older", int'(flush_valid), 0);
    do_retire("R3"); do_retire("R3"); do_retire("R3");
    do_done(6, "R3"); do_retire("R3"); do_retire("R3");
    chk(q_empty && head_idx == 0, "R3", "wrapped empty", int'(head_idx), 0);

    // R8: eviction acts as invalidation
    do_alloc(50, 0, "R8"); do_alloc(51, 0, "R8");
    do_done(1, "R8");
    do_snoop(51, 1, "R8");
    chk(flush_valid && flush_idx == 1, "R8", "evict flush", int'(flush_idx), 1);

    // R9: oldest of several matches
    do_alloc(60, 0, "R9"); do_alloc(60, 0, "R9"); do_alloc(60, 0, "R9");
    do_done(2, "R9"); do_done(3, "R9");
    do_snoop(60, 0, "R9");
    chk(flush_valid && flush_idx == 2, "R9", "oldest match", int'(flush_idx), 2);

    // R10: allocation in the flush cycle is discarded
    do_alloc(70, 0, "R10"); do_done(2, "R10");
    snp_line = LW'(70); snp_inv = 1; alloc_valid = 1; alloc_line = LW'(71);
    tick("R10"); clear_inputs();
    chk(q_count == 2 && tail_idx == 2, "R10", "alloc dropped", int'(q_count), 2);

    // R3: retire of an incomplete head is ignored
    do_retire("R3");
    chk(head_idx == 0, "R3", "pending head kept", int'(head_idx), 0);
    do_done(1, "R3"); do_retire("R3");
    chk(head_idx == 0, "R3", "still pending head", int'(head_idx), 0);
    do_done(0, "R3"); do_retire("R3");
    chk(head_idx == 1, "R3", "retire done head", int'(head_idx), 1);

    // R2: fill and overflow
    for (int i = 0; i < 7; i++) do_alloc(80 + i, 0, "R2");
    chk(q_full == 1, "R2", "full", int'(q_full), 1);
    do_alloc(99, 0, "R2");
    chk(q_count == D, "R2", "alloc when full", int'(q_count), D);

    // Mixed traffic against the model
    for (int n = 0; n < 4000; n++) begin
      alloc_valid  = ($urandom % 2) == 0;
      alloc_line   = LW'($urandom % 4);
      alloc_wc     = ($urandom % 8) == 0;
      done_valid   = ($urandom % 2) == 0;
      done_idx     = IW'($urandom % D);
      retire_valid = ($urandom % 3) == 0;
      snp_line     = LW'($urandom % 4);
      snp_inv      = ($urandom % 5) == 0;
      snp_evict    = !snp_inv && (($urandom % 6) == 0);
      tick("R4/R9/R10");
    end
    clear_inputs();

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule